// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block corrects the two source operands of the instruction sitting in the decode stage of a five-stage, 32-bit pipeline. The register file can still hold an old value for a register that an older instruction has not yet written back. Each source register number is compared with the destination registers of the instructions now in execute, memory and writeback. That makes six comparisons in total. When a stage will write the register being read, its result replaces the register-file read.

The corrected operands leave the block in two forms. The combinational copies go to the branch equality compare in decode, so a branch resolved early sees current data. The registered copies form the operand latch that feeds the ALU in the next cycle.

The execute-stage destination is chosen inside the block from that instruction's rt and rd fields by a register-destination control. The writeback value is chosen from memory read data or the ALU result by a memory-to-register control. Register 0 is never forwarded. As a result, a jump whose link write has been steered to register 0 cannot leak its value into a following instruction.

Top module: `decode_fwd_unit`

## Requirements
- R1: The execute-stage destination is `ex_rd` when `ex_reg_dst` is 1 and `ex_rt` when it is 0.
- R2: The writeback value is `wb_mem_rdata` when `wb_mem_to_reg` is 1 and `wb_alu_result` when it is 0.
- R3: When a source number equals the execute destination, that destination is nonzero and `ex_reg_we` is 1, the operand equals `ex_alu_result`.
- R4: When a source matches only the memory-stage destination (nonzero, `mem_reg_we`=1), the operand equals `mem_alu_result`.
- R5: When a source matches only the writeback destination (nonzero, `wb_reg_we`=1), the operand equals the writeback value of R2.
- R6: When several stages match, the youngest wins: execute over memory over writeback.
- R7: A stage whose write enable is 0 never forwards, even when its destination matches.
- R8: A source of register 0 always passes the register-file value through, whatever the later stages hold.
- R9: With no qualifying match, each operand equals its register-file read.
- R10: The two sources are resolved independently and may take values from different stages in the same cycle.
- R11: On each rising clock edge the latch outputs take the corrected operands. While `rst_n` is 0 at an edge (synchronous, active low), they clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand latch |
| rst_n | input | 1 | Synchronous active-low reset of the latch |
| id_rs_a | input | 5 | First decode source register number |
| id_rs_b | input | 5 | Second decode source register number |
| rf_rdata_a | input | 32 | Register-file read for the first source |
| rf_rdata_b | input | 32 | Register-file read for the second source |
| ex_rt | input | 5 | rt field of the execute-stage instruction |
| ex_rd | input | 5 | rd field of the execute-stage instruction |
| ex_reg_dst | input | 1 | 1 selects rd, 0 selects rt as execute destination |
| ex_reg_we | input | 1 | Execute-stage instruction will write a register |
| ex_alu_result | input | 32 | Execute-stage result |
| mem_dest | input | 5 | Memory-stage destination register |
| mem_reg_we | input | 1 | Memory-stage instruction will write a register |
| mem_alu_result | input | 32 | Memory-stage ALU result |
| wb_dest | input | 5 | Writeback destination register |
| wb_reg_we | input | 1 | Writeback instruction writes a register |
| wb_mem_to_reg | input | 1 | 1 selects memory data, 0 the ALU result |
| wb_mem_rdata | input | 32 | Writeback memory read data |
| wb_alu_result | input | 32 | Writeback ALU result |
| opnd_a | output | 32 | Corrected first operand (to branch compare) |
| opnd_b | output | 32 | Corrected second operand (to branch compare) |
| ex_latch_a | output | 32 | Registered first operand (to ALU) |
| ex_latch_b | output | 32 | Registered second operand (to ALU) |

## Verification
The bench targets the cases where several stages claim the same register. A design with the priority reversed would hand the decode stage a value that is one or two instructions stale.

Other scenarios check specific faults:
- Register 0 held in every later stage with write enables high: a design that skips the zero test would forward a link address or a garbage result into an operand that must read zero.
- A matching destination with its write enable low: a design that ignores the enable would forward data from stores and branches.
- Both polarities of the destination and writeback selects: a design with a select swapped would compare against the wrong field or pass the wrong data.
- Two sources served by different stages in the same cycle: this exposes a design that lets one source's match steer the other.

// File: rtl/fwd_pkg.sv
// Shared definitions for the decode-stage forwarding unit.
// Assumes three later pipeline stages, ordered youngest first.
package fwd_pkg;
    localparam int NUM_STAGES = 3;

    // Where a corrected operand comes from.
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } fwd_src_e;
endpackage

// File: rtl/fwd_dest_sel.sv
// Picks the destination register of an instruction from its rt and rd
// fields. Assumes use_rd is high for register-to-register operations.
module fwd_dest_sel #(
    parameter int REGW = 5
) (
    input  logic [REGW-1:0] rt,
    input  logic [REGW-1:0] rd,
    input  logic            use_rd,
    output logic [REGW-1:0] dest
);
    // Steer the destination field.
    always_comb dest = use_rd ? rd : rt;
endmodule

// File: rtl/fwd_wb_sel.sv
// Forms the value a writeback instruction commits: memory data or the
// ALU result. Assumes both inputs are already stable for the cycle.
module fwd_wb_sel #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [XLEN-1:0] alu_result,
    input  logic            mem_to_reg,
    output logic [XLEN-1:0] value
);
    // Choose the committed value.
    always_comb value = mem_to_reg ? mem_rdata : alu_result;
endmodule

// File: rtl/fwd_match.sv
// Compares one source register number with the destinations of the later
// stages and reports which stage, if any, supplies the operand. Index 0 is
// the youngest stage and wins ties. Register 0 never matches.
module fwd_match
    import fwd_pkg::*;
#(
    parameter int REGW   = 5,
    parameter int NSTAGE = NUM_STAGES
) (
    input  logic [REGW-1:0]             src,
    input  logic [NSTAGE-1:0][REGW-1:0] dests,
    input  logic [NSTAGE-1:0]           wes,
    output fwd_src_e                    sel
);
    logic [NSTAGE-1:0] hit;
    logic              src_nonzero;

    // Register 0 is hard-wired and is never bypassed.
    always_comb src_nonzero = (src != '0);

    genvar s;
    generate
        for (s = 0; s < NSTAGE; s++) begin : g_cmp
            // One equality comparator per later stage.
            always_comb hit[s] = wes[s] && src_nonzero && (dests[s] == src);
        end
    endgenerate

    // Priority pick: scan oldest to youngest so the youngest hit remains.
    always_comb begin
        sel = SRC_RF;
        for (int i = NSTAGE - 1; i >= 0; i--) begin
            if (hit[i]) sel = fwd_src_e'(2'(i + 1));
        end
    end
endmodule

// File: rtl/fwd_operand_mux.sv
// Selects the corrected operand from the register-file read or one of the
// later-stage values, under control of a fwd_match result.
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fwd_src_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] ex_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] out
);
    // Four-way operand select.
    always_comb begin
        unique case (sel)
            SRC_EX:  out = ex_val;
            SRC_MEM: out = mem_val;
            SRC_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/decode_fwd_unit.sv
// Decode-stage operand forwarding. Both source operands of the decode
// instruction are corrected against execute, memory and writeback
// destinations (six comparators). The corrected values leave combinationally
// for the branch compare and through a latch for the ALU. Assumes load-use
// stalls are handled elsewhere, so the memory stage forwards its ALU result.
module decode_fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REGW-1:0] id_rs_a,
    input  logic [REGW-1:0] id_rs_b,
    input  logic [XLEN-1:0] rf_rdata_a,
    input  logic [XLEN-1:0] rf_rdata_b,
    input  logic [REGW-1:0] ex_rt,
    input  logic [REGW-1:0] ex_rd,
    input  logic            ex_reg_dst,
    input  logic            ex_reg_we,
    input  logic [XLEN-1:0] ex_alu_result,
    input  logic [REGW-1:0] mem_dest,
    input  logic            mem_reg_we,
    input  logic [XLEN-1:0] mem_alu_result,
    input  logic [REGW-1:0] wb_dest,
    input  logic            wb_reg_we,
    input  logic            wb_mem_to_reg,
    input  logic [XLEN-1:0] wb_mem_rdata,
    input  logic [XLEN-1:0] wb_alu_result,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] ex_latch_a,
    output logic [XLEN-1:0] ex_latch_b
);
    localparam int NSRC = 2;

    logic [REGW-1:0]                ex_dest;
    logic [XLEN-1:0]                wb_value;
    logic [NUM_STAGES-1:0][REGW-1:0] stage_dest;
    logic [NUM_STAGES-1:0]          stage_we;
    logic [NSRC-1:0][REGW-1:0]      src_num;
    logic [NSRC-1:0][XLEN-1:0]      src_rf;
    logic [NSRC-1:0][XLEN-1:0]      src_out;

    fwd_dest_sel #(.REGW(REGW)) u_ex_dest (
        .rt     (ex_rt),
        .rd     (ex_rd),
        .use_rd (ex_reg_dst),
        .dest   (ex_dest)
    );

    fwd_wb_sel #(.XLEN(XLEN)) u_wb_val (
        .mem_rdata  (wb_mem_rdata),
        .alu_result (wb_alu_result),
        .mem_to_reg (wb_mem_to_reg),
        .value      (wb_value)
    );

    // Pack stage information youngest first and gather the sources.
    always_comb begin
        stage_dest = {wb_dest, mem_dest, ex_dest};
        stage_we   = {wb_reg_we, mem_reg_we, ex_reg_we};
        src_num    = {id_rs_b, id_rs_a};
        src_rf     = {rf_rdata_b, rf_rdata_a};
    end

    genvar k;
    generate
        for (k = 0; k < NSRC; k++) begin : g_src
            fwd_src_e sel;

            fwd_match #(.REGW(REGW), .NSTAGE(NUM_STAGES)) u_match (
                .src   (src_num[k]),
                .dests (stage_dest),
                .wes   (stage_we),
                .sel   (sel)
            );

            fwd_operand_mux #(.XLEN(XLEN)) u_mux (
                .sel     (sel),
                .rf_val  (src_rf[k]),
                .ex_val  (ex_alu_result),
                .mem_val (mem_alu_result),
                .wb_val  (wb_value),
                .out     (src_out[k])
            );
        end
    endgenerate

    // Expose the corrected operands to the branch compare.
    always_comb begin
        opnd_a = src_out[0];
        opnd_b = src_out[1];
    end

    // Operand latch into the execute stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_latch_a <= '0;
            ex_latch_b <= '0;
        end else begin
            ex_latch_a <= src_out[0];
            ex_latch_b <= src_out[1];
        end
    end
endmodule

// File: rtl/decode_fwd_checker.sv
// Property checker for decode_fwd_unit, attached through bind. Observes the
// ports only and checks the forwarding rules from the brief.
module decode_fwd_checker #(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [REGW-1:0] id_rs_a,
    input logic [REGW-1:0] id_rs_b,
    input logic [XLEN-1:0] rf_rdata_a,
    input logic [XLEN-1:0] rf_rdata_b,
    input logic [REGW-1:0] ex_rt,
    input logic [REGW-1:0] ex_rd,
    input logic            ex_reg_dst,
    input logic            ex_reg_we,
    input logic [XLEN-1:0] ex_alu_result,
    input logic [REGW-1:0] mem_dest,
    input logic            mem_reg_we,
    input logic [XLEN-1:0] mem_alu_result,
    input logic [REGW-1:0] wb_dest,
    input logic            wb_reg_we,
    input logic            wb_mem_to_reg,
    input logic [XLEN-1:0] wb_mem_rdata,
    input logic [XLEN-1:0] wb_alu_result,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [XLEN-1:0] ex_latch_a,
    input logic [XLEN-1:0] ex_latch_b
);
    logic ex_hit_a, mem_hit_a, wb_only_a;

    // Reference hit conditions for source A.
    always_comb begin
        ex_hit_a  = ex_reg_we && (id_rs_a != '0) &&
                    (id_rs_a == (ex_reg_dst ? ex_rd : ex_rt));
        mem_hit_a = mem_reg_we && (id_rs_a != '0) && (id_rs_a == mem_dest);
        wb_only_a = !ex_hit_a && !mem_hit_a && wb_reg_we &&
                    (id_rs_a != '0) && (id_rs_a == wb_dest);
    end

    // R1: rd is the destination when ex_reg_dst is 1.
    assert_ex_rd_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_reg_we && ex_reg_dst && ex_rd != '0 && id_rs_a == ex_rd) |-> (opnd_a == ex_alu_result));

    // R3: execute hit through the rt field.
    assert_ex_rt_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_reg_we && !ex_reg_dst && ex_rt != '0 && id_rs_b == ex_rt) |-> (opnd_b == ex_alu_result));

    // R2 and R5: writeback-only hit delivers the selected writeback value.
    assert_wb_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_only_a |-> (opnd_a == (wb_mem_to_reg ? wb_mem_rdata : wb_alu_result)));

    // R6: memory beats writeback when execute does not hit.
    assert_mem_over_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_hit_a && mem_hit_a) |-> (opnd_a == mem_alu_result));

    // R7: no enabled stage means no forwarding at all.
    assert_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_reg_we && !mem_reg_we && !wb_reg_we) |-> (opnd_a == rf_rdata_a && opnd_b == rf_rdata_b));

    // R8: register 0 passes the register-file value.
    assert_reg0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs_a == '0) |-> (opnd_a == rf_rdata_a));

    // R11: latch follows the corrected operands one edge later.
    assert_latch_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ex_latch_a == $past(opnd_a) && ex_latch_b == $past(opnd_b)));

    // R11: reset clears the latch.
    assert_latch_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (ex_latch_a == '0 && ex_latch_b == '0));
endmodule

bind decode_fwd_unit decode_fwd_checker #(.XLEN(XLEN), .REGW(REGW)) u_chk (.*);

// File: tb/decode_fwd_unit_tb.sv
// Directed bench for decode_fwd_unit: one task per scenario.
module decode_fwd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  id_rs_a, id_rs_b, ex_rt, ex_rd, mem_dest, wb_dest;
    logic [31:0] rf_rdata_a, rf_rdata_b, ex_alu_result, mem_alu_result;
    logic [31:0] wb_mem_rdata, wb_alu_result;
    logic        ex_reg_dst, ex_reg_we, mem_reg_we, wb_reg_we, wb_mem_to_reg;
    logic [31:0] opnd_a, opnd_b, ex_latch_a, ex_latch_b;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    decode_fwd_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_reg_dst(ex_reg_dst),
        .ex_reg_we(ex_reg_we), .ex_alu_result(ex_alu_result),
        .mem_dest(mem_dest), .mem_reg_we(mem_reg_we),
        .mem_alu_result(mem_alu_result),
        .wb_dest(wb_dest), .wb_reg_we(wb_reg_we),
        .wb_mem_to_reg(wb_mem_to_reg), .wb_mem_rdata(wb_mem_rdata),
        .wb_alu_result(wb_alu_result),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ex_latch_a(ex_latch_a), .ex_latch_b(ex_latch_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Quiet pipeline: distinct data everywhere, no enables.
    task automatic idle();
        @(negedge clk);
        id_rs_a = 5'd3; id_rs_b = 5'd4;
        rf_rdata_a = 32'hA000_0003; rf_rdata_b = 32'hB000_0004;
        ex_rt = 5'd10; ex_rd = 5'd11; ex_reg_dst = 1'b1; ex_reg_we = 1'b0;
        ex_alu_result = 32'hE000_0001;
        mem_dest = 5'd12; mem_reg_we = 1'b0; mem_alu_result = 32'hC000_0002;
        wb_dest = 5'd13; wb_reg_we = 1'b0; wb_mem_to_reg = 1'b0;
        wb_mem_rdata = 32'hD000_0003; wb_alu_result = 32'hF000_0004;
    endtask

    task automatic t_reset();
        idle();
        @(posedge clk); #1;
        chk("R11 reset latch a", ex_latch_a, 32'h0);
        chk("R11 reset latch b", ex_latch_b, 32'h0);
    endtask

    task automatic t_no_match();
        idle();
        ex_reg_we = 1'b1; mem_reg_we = 1'b1; wb_reg_we = 1'b1;
        #1;
        chk("R9 no match a", opnd_a, 32'hA000_0003);
        chk("R9 no match b", opnd_b, 32'hB000_0004);
    endtask

    task automatic t_ex_fields();
        idle();
        ex_reg_we = 1'b1; ex_reg_dst = 1'b1; id_rs_a = 5'd11; id_rs_b = 5'd10;
        #1;
        chk("R1 rd selected", opnd_a, 32'hE000_0001);
        chk("R1 rt ignored when rd chosen", opnd_b, 32'hB000_0004);
        ex_reg_dst = 1'b0;
        #1;
        chk("R3 rt forward", opnd_b, 32'hE000_0001);
        chk("R1 rd ignored when rt chosen", opnd_a, 32'hA000_0003);
    endtask

    task automatic t_mem();
        idle();
        mem_reg_we = 1'b1; id_rs_a = 5'd12;
        #1;
        chk("R4 mem forward", opnd_a, 32'hC000_0002);
    endtask

    task automatic t_wb();
        idle();
        wb_reg_we = 1'b1; id_rs_b = 5'd13; wb_mem_to_reg = 1'b0;
        #1;
        chk("R5 wb alu forward", opnd_b, 32'hF000_0004);
        wb_mem_to_reg = 1'b1;
        #1;
        chk("R2 wb memory data forward", opnd_b, 32'hD000_0003);
    endtask

    task automatic t_priority();
        idle();
        ex_reg_dst = 1'b1; ex_rd = 5'd7; mem_dest = 5'd7; wb_dest = 5'd7;
        ex_reg_we = 1'b1; mem_reg_we = 1'b1; wb_reg_we = 1'b1; id_rs_a = 5'd7;
        #1;
        chk("R6 ex beats mem and wb", opnd_a, 32'hE000_0001);
        ex_reg_we = 1'b0;
        #1;
        chk("R6 mem beats wb", opnd_a, 32'hC000_0002);
    endtask

    task automatic t_we_low();
        idle();
        ex_rd = 5'd3; mem_dest = 5'd3; wb_dest = 5'd4;
        #1;
        chk("R7 disabled ex/mem ignored", opnd_a, 32'hA000_0003);
        chk("R7 disabled wb ignored", opnd_b, 32'hB000_0004);
    endtask

    task automatic t_zero();
        idle();
        id_rs_a = 5'd0; id_rs_b = 5'd0; rf_rdata_a = 32'h0; rf_rdata_b = 32'h0;
        ex_rd = 5'd0; mem_dest = 5'd0; wb_dest = 5'd0;
        ex_reg_we = 1'b1; mem_reg_we = 1'b1; wb_reg_we = 1'b1;
        #1;
        chk("R8 reg0 not forwarded a", opnd_a, 32'h0);
        chk("R8 reg0 not forwarded b", opnd_b, 32'h0);
    endtask

    task automatic t_independent();
        idle();
        ex_reg_we = 1'b1; ex_rd = 5'd5; id_rs_a = 5'd5;
        wb_reg_we = 1'b1; wb_dest = 5'd6; id_rs_b = 5'd6; wb_mem_to_reg = 1'b1;
        #1;
        chk("R10 a from ex", opnd_a, 32'hE000_0001);
        chk("R10 b from wb", opnd_b, 32'hD000_0003);
        @(posedge clk); #1;
        chk("R11 latch a", ex_latch_a, 32'hE000_0001);
        chk("R11 latch b", ex_latch_b, 32'hD000_0003);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_no_match();
        t_ex_fields();
        t_mem();
        t_wb();
        t_priority();
        t_we_low();
        t_zero();
        t_independent();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule